// File: doc/BRIEF.md
# Calibration Table Builder

This block turns a short, unordered list of calibration pairs into a dense table of evenly spaced breakpoints for a later interpolator. Each pair holds a converter code and a physical value. A mode input picks which of the two acts as the independent axis. In output-converter mode the physical value is the independent variable. In input-converter mode the converter code is.

A start pulse launches a build, for example at power-up or after the stored calibration has changed. The block first reads the pairs one at a time from a synchronous memory. It drops any pair whose independent value has already been seen, and inserts each survivor into an ascending list. It then walks the table grid. For each grid position it selects the two sorted pairs that bracket that position and computes the dependent value on the straight line between them, using a serial divider. Each entry is written out through a simple write port. Zero or one surviving pairs give flat tables with defined contents.

Top module: `cal_lut_builder`

## Requirements
- R1: While `busy` is low, a `start` high on a clock edge begins a build, and `busy` is high from the next cycle until the cycle in which `done` is high. A `start` seen while `busy` is high changes nothing.
- R2: The number of pairs used is n = min(`pair_count`, MAX_PAIRS). The block issues exactly n reads with `rd_addr` = 0, 1, ..., n-1, one read per `rd_en` cycle, and never two reads in consecutive cycles. `rd_data` is taken one cycle after `rd_en`. Bits [2*VAL_W-1:VAL_W] hold the converter code and bits [VAL_W-1:0] hold the physical value.
- R3: With `mode`=0 the physical value is the independent key and the code is the dependent value. With `mode`=1 the roles swap. `mode` is sampled together with `start`.
- R4: A pair whose key equals the key of a pair at a lower address is ignored, so the earliest stored pair wins. A repeat of an identical pair leaves the table unchanged.
- R5: The table depends only on the set of surviving pairs, not on their storage order.
- R6: A build writes NPTS = 2^GRID_LOG2 + 1 entries, one per `lut_we` cycle, at `lut_addr` 0 to NPTS-1 in ascending order. Entry k belongs to grid position x_k = min(k * 2^(VAL_W-GRID_LOG2), 2^VAL_W - 1).
- R7: With at least two pairs sorted by key, entry k uses the segment lo = clamp(c-1, 0, n'-2), where c is the number of keys not above x_k and n' is the number of surviving pairs. Its value is y_lo + ((y_lo+1 - y_lo) * (x_k - x_lo)) / (x_lo+1 - x_lo), with the division truncated toward zero.
- R8: Grid positions outside the key range are extrapolated from the outermost segment, and each result is clamped to the range 0 to 2^VAL_W - 1.
- R9: With no surviving pairs, every entry is written as 0.
- R10: With exactly one surviving pair, every entry is written with that pair's dependent value.
- R11: `done` is high for one cycle, in the cycle after the final table write.
- R12: Every accepted start runs a fresh build from the current memory contents, keeping nothing from earlier builds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Build request pulse |
| mode | input | 1 | 0: physical value is the key, 1: code is the key |
| pair_count | input | CNT_W | Number of stored pairs |
| rd_en | output | 1 | Pair memory read strobe |
| rd_addr | output | ADDR_W | Pair memory address |
| rd_data | input | 2*VAL_W | Pair read back one cycle after `rd_en` |
| lut_we | output | 1 | Table write strobe |
| lut_addr | output | GRID_LOG2+1 | Table entry index |
| lut_data | output | VAL_W | Table entry value |
| busy | output | 1 | Build in progress |
| done | output | 1 | One-cycle end-of-build pulse |

## Verification
The bench keeps MAX_PAIRS at its default of 60 and VAL_W at 12, and sets GRID_LOG2 to 3, which gives a nine-entry grid with a spacing of 512 and a final point clamped to 4095. A stored count of 63 therefore exercises the count clamp and fills the insertion array completely, while keeping each build short. The short grid also lets several scenarios fit in one run: both degenerate cases, duplicate keys in each mode, shuffled storage, steep extrapolation into both clamp limits, a restart attempt during a build, and a rebuild after the memory changes.

// File: rtl/cal_lut_pkg.sv
package cal_lut_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_CAP,
    ST_SEG,
    ST_DIV,
    ST_WR
  } bld_state_t;
endpackage

// File: rtl/cal_pair_sorter.sv
module cal_pair_sorter #(
  parameter int MAX_PAIRS = 60,
  parameter int VAL_W     = 12,
  localparam int CNT_W    = $clog2(MAX_PAIRS + 1)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                clr,
  input  logic                                ins_en,
  input  logic [VAL_W-1:0]                    ins_key,
  input  logic [VAL_W-1:0]                    ins_dep,
  output logic [MAX_PAIRS-1:0][VAL_W-1:0]     keys,
  output logic [MAX_PAIRS-1:0][VAL_W-1:0]     deps,
  output logic [CNT_W-1:0]                    count
);
  logic [MAX_PAIRS-1:0]               lt_v;
  logic [MAX_PAIRS-1:0]               eq_v;
  logic [CNT_W-1:0]                   pos;
  logic                               dup;
  logic                               take;
  logic [MAX_PAIRS-1:0][VAL_W-1:0]    keys_nx;
  logic [MAX_PAIRS-1:0][VAL_W-1:0]    deps_nx;
  logic [CNT_W-1:0]                   count_nx;

  // insertion point and duplicate search over the occupied slots
  always_comb begin
    pos = '0;
    for (int j = 0; j < MAX_PAIRS; j++) begin
      lt_v[j] = (CNT_W'(j) < count) && (keys[j] < ins_key);
      eq_v[j] = (CNT_W'(j) < count) && (keys[j] == ins_key);
      if (lt_v[j]) pos = pos + 1'b1;
    end
    dup  = |eq_v;
    take = ins_en && !dup && (count < CNT_W'(MAX_PAIRS));
  end

  always_comb begin
    keys_nx  = keys;
    deps_nx  = deps;
    count_nx = count;
    if (clr) begin
      count_nx = '0;
    end else if (take) begin
      count_nx = count + 1'b1;
      for (int j = 0; j < MAX_PAIRS; j++) begin
        if (CNT_W'(j) == pos) begin
          keys_nx[j] = ins_key;
          deps_nx[j] = ins_dep;
        end else if (CNT_W'(j) > pos) begin
          keys_nx[j] = keys[(j > 0) ? j - 1 : 0];
          deps_nx[j] = deps[(j > 0) ? j - 1 : 0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keys  <= '0;
      deps  <= '0;
      count <= '0;
    end else if (clr || take) begin
      keys  <= keys_nx;
      deps  <= deps_nx;
      count <= count_nx;
    end
  end
endmodule

// File: rtl/cal_seg_pick.sv
module cal_seg_pick #(
  parameter int MAX_PAIRS = 60,
  parameter int VAL_W     = 12,
  localparam int CNT_W    = $clog2(MAX_PAIRS + 1)
) (
  input  logic [MAX_PAIRS-1:0][VAL_W-1:0] keys,
  input  logic [MAX_PAIRS-1:0][VAL_W-1:0] deps,
  input  logic [CNT_W-1:0]                count,
  input  logic [VAL_W-1:0]                x,
  output logic [VAL_W-1:0]                x0,
  output logic [VAL_W-1:0]                x1,
  output logic [VAL_W-1:0]                y0,
  output logic [VAL_W-1:0]                y1
);
  logic [CNT_W-1:0] below;
  logic [CNT_W-1:0] lo;
  logic [CNT_W-1:0] hi;

  always_comb begin
    below = '0;
    for (int j = 0; j < MAX_PAIRS; j++) begin
      if ((CNT_W'(j) < count) && (keys[j] <= x)) below = below + 1'b1;
    end
    if (count < CNT_W'(2) || below == '0)
      lo = '0;
    else if (below - 1'b1 > count - CNT_W'(2))
      lo = count - CNT_W'(2);
    else
      lo = below - 1'b1;
    hi = lo + 1'b1;
    x0 = keys[lo];
    x1 = keys[hi];
    y0 = deps[lo];
    y1 = deps[hi];
  end
endmodule

// File: rtl/cal_div.sv
module cal_div #(
  parameter int NW = 26,
  parameter int DW = 12,
  localparam int CW = $clog2(NW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          done,
  output logic [NW-1:0] quo
);
  logic [DW-1:0] rem_q, rem_nx;
  logic [DW-1:0] den_q, den_nx;
  logic [NW-1:0] quo_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          run_q, run_nx;
  logic          done_nx;
  logic [DW+1:0] diff;

  // one restoring step per cycle
  always_comb begin
    diff    = {1'b0, rem_q, quo[NW-1]} - {2'b00, den_q};
    rem_nx  = rem_q;
    den_nx  = den_q;
    quo_nx  = quo;
    cnt_nx  = cnt_q;
    run_nx  = run_q;
    done_nx = 1'b0;
    if (start) begin
      rem_nx = '0;
      den_nx = den;
      quo_nx = num;
      cnt_nx = CW'(NW);
      run_nx = 1'b1;
    end else if (run_q) begin
      if (!diff[DW+1]) begin
        rem_nx = diff[DW-1:0];
        quo_nx = {quo[NW-2:0], 1'b1};
      end else begin
        rem_nx = {rem_q[DW-2:0], quo[NW-1]};
        quo_nx = {quo[NW-2:0], 1'b0};
      end
      cnt_nx = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_nx  = 1'b0;
        done_nx = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      den_q <= '0;
      quo   <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      rem_q <= rem_nx;
      den_q <= den_nx;
      quo   <= quo_nx;
      cnt_q <= cnt_nx;
      run_q <= run_nx;
      done  <= done_nx;
    end
  end
endmodule

// File: rtl/cal_lut_builder.sv
module cal_lut_builder #(
  parameter int MAX_PAIRS = 60,
  parameter int VAL_W     = 12,
  parameter int GRID_LOG2 = 4,
  localparam int CNT_W    = $clog2(MAX_PAIRS + 1),
  localparam int ADDR_W   = $clog2(MAX_PAIRS),
  localparam int GK_W     = GRID_LOG2 + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 mode,
  input  logic [CNT_W-1:0]     pair_count,
  output logic                 rd_en,
  output logic [ADDR_W-1:0]    rd_addr,
  input  logic [2*VAL_W-1:0]   rd_data,
  output logic                 lut_we,
  output logic [GK_W-1:0]      lut_addr,
  output logic [VAL_W-1:0]     lut_data,
  output logic                 busy,
  output logic                 done
);
  import cal_lut_pkg::*;

  localparam int NPTS   = (1 << GRID_LOG2) + 1;
  localparam int STEP_W = VAL_W - GRID_LOG2;
  localparam int PW     = 2 * VAL_W + 2;
  localparam int EW     = PW + 1;
  localparam logic [VAL_W-1:0] VMAX = {VAL_W{1'b1}};

  // asynchronous assertion, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  bld_state_t          st_q, st_nx;
  logic [CNT_W-1:0]    idx_q, idx_nx;
  logic [CNT_W-1:0]    tot_q, tot_nx;
  logic [GK_W-1:0]     gk_q, gk_nx;
  logic [VAL_W-1:0]    y_q, y_nx;
  logic [VAL_W-1:0]    ybase_q, ybase_nx;
  logic                neg_q, neg_nx;
  logic                mode_q, mode_nx;
  logic                done_nx;

  logic                srt_clr, srt_ins;
  logic [VAL_W-1:0]    ins_key, ins_dep;
  logic [MAX_PAIRS-1:0][VAL_W-1:0] keys, deps;
  logic [CNT_W-1:0]    n_pairs;

  logic [VAL_W:0]      gx_wide;
  logic [VAL_W-1:0]    gx;
  logic [VAL_W-1:0]    sx0, sx1, sy0, sy1;
  logic signed [PW-1:0] prod;
  logic [PW-1:0]       mag;
  logic                div_go, div_done;
  logic [PW-1:0]       quo;
  logic signed [EW-1:0] ysum;
  logic [VAL_W-1:0]    yclamp;

  assign ins_key = mode_q ? rd_data[2*VAL_W-1:VAL_W] : rd_data[VAL_W-1:0];
  assign ins_dep = mode_q ? rd_data[VAL_W-1:0]       : rd_data[2*VAL_W-1:VAL_W];

  cal_pair_sorter #(.MAX_PAIRS(MAX_PAIRS), .VAL_W(VAL_W)) u_sort (
    .clk(clk), .rst_n(rst_i_n), .clr(srt_clr), .ins_en(srt_ins),
    .ins_key(ins_key), .ins_dep(ins_dep),
    .keys(keys), .deps(deps), .count(n_pairs)
  );

  // grid position for the current entry; last point saturates
  assign gx_wide = {gk_q, {STEP_W{1'b0}}};
  assign gx      = (gx_wide > {1'b0, VMAX}) ? VMAX : gx_wide[VAL_W-1:0];

  cal_seg_pick #(.MAX_PAIRS(MAX_PAIRS), .VAL_W(VAL_W)) u_pick (
    .keys(keys), .deps(deps), .count(n_pairs), .x(gx),
    .x0(sx0), .x1(sx1), .y0(sy0), .y1(sy1)
  );

  assign prod = $signed({{(PW-VAL_W){1'b0}}, sy1}) - $signed({{(PW-VAL_W){1'b0}}, sy0});
  logic signed [PW-1:0] dxs;
  logic signed [PW-1:0] full_prod;
  assign dxs       = $signed({{(PW-VAL_W){1'b0}}, gx}) - $signed({{(PW-VAL_W){1'b0}}, sx0});
  assign full_prod = prod * dxs;
  assign mag       = full_prod[PW-1] ? PW'(-full_prod) : full_prod;
  assign div_go    = (st_q == ST_SEG) && (n_pairs >= CNT_W'(2));

  cal_div #(.NW(PW), .DW(VAL_W)) u_div (
    .clk(clk), .rst_n(rst_i_n), .start(div_go), .num(mag),
    .den(sx1 - sx0), .done(div_done), .quo(quo)
  );

  always_comb begin
    ysum = neg_q ? $signed({{(EW-VAL_W){1'b0}}, ybase_q}) - $signed({1'b0, quo})
                 : $signed({{(EW-VAL_W){1'b0}}, ybase_q}) + $signed({1'b0, quo});
    if (ysum < 0)
      yclamp = '0;
    else if (ysum > $signed({{(EW-VAL_W){1'b0}}, VMAX}))
      yclamp = VMAX;
    else
      yclamp = ysum[VAL_W-1:0];
  end

  always_comb begin
    st_nx    = st_q;
    idx_nx   = idx_q;
    tot_nx   = tot_q;
    gk_nx    = gk_q;
    y_nx     = y_q;
    ybase_nx = ybase_q;
    neg_nx   = neg_q;
    mode_nx  = mode_q;
    done_nx  = 1'b0;
    srt_clr  = 1'b0;
    srt_ins  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        srt_clr = 1'b1;
        mode_nx = mode;
        idx_nx  = '0;
        gk_nx   = '0;
        tot_nx  = (pair_count > CNT_W'(MAX_PAIRS)) ? CNT_W'(MAX_PAIRS) : pair_count;
        st_nx   = (pair_count == '0) ? ST_SEG : ST_REQ;
      end
      ST_REQ: st_nx = ST_CAP;
      ST_CAP: begin
        srt_ins = 1'b1;
        idx_nx  = idx_q + 1'b1;
        st_nx   = (idx_q + 1'b1 == tot_q) ? ST_SEG : ST_REQ;
      end
      ST_SEG: begin
        if (n_pairs == '0) begin
          y_nx  = '0;
          st_nx = ST_WR;
        end else if (n_pairs == CNT_W'(1)) begin
          y_nx  = deps[0];
          st_nx = ST_WR;
        end else begin
          ybase_nx = sy0;
          neg_nx   = full_prod[PW-1];
          st_nx    = ST_DIV;
        end
      end
      ST_DIV: if (div_done) begin
        y_nx  = yclamp;
        st_nx = ST_WR;
      end
      ST_WR: begin
        if (gk_q == GK_W'(NPTS - 1)) begin
          done_nx = 1'b1;
          st_nx   = ST_IDLE;
        end else begin
          gk_nx = gk_q + 1'b1;
          st_nx = ST_SEG;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      tot_q   <= '0;
      gk_q    <= '0;
      y_q     <= '0;
      ybase_q <= '0;
      neg_q   <= 1'b0;
      mode_q  <= 1'b0;
      done    <= 1'b0;
    end else begin
      st_q    <= st_nx;
      idx_q   <= idx_nx;
      tot_q   <= tot_nx;
      gk_q    <= gk_nx;
      y_q     <= y_nx;
      ybase_q <= ybase_nx;
      neg_q   <= neg_nx;
      mode_q  <= mode_nx;
      done    <= done_nx;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign rd_en    = (st_q == ST_REQ);
  assign rd_addr  = idx_q[ADDR_W-1:0];
  assign lut_we   = (st_q == ST_WR);
  assign lut_addr = gk_q;
  assign lut_data = y_q;
endmodule

// File: rtl/cal_lut_builder_chk.sv
module cal_lut_builder_chk #(
  parameter int MAX_PAIRS = 60,
  parameter int GRID_LOG2 = 4,
  parameter int ADDR_W    = 6,
  parameter int GK_W      = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              lut_we,
  input logic [GK_W-1:0]   lut_addr,
  input logic              busy,
  input logic              done
);
  localparam int NPTS = (1 << GRID_LOG2) + 1;

  logic [GK_W-1:0] wr_expect;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wr_expect <= '0;
    else if (!busy)  wr_expect <= '0;
    else if (lut_we) wr_expect <= wr_expect + 1'b1;
  end

  assert_busy_from_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  assert_start_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
  assert_busy_ends_with_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_single_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);
  assert_read_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (busy && (rd_addr < ADDR_W'(MAX_PAIRS))));
  assert_write_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lut_we |-> (busy && (lut_addr == wr_expect)));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(lut_we) && ($past(lut_addr) == GK_W'(NPTS - 1))));
endmodule

bind cal_lut_builder cal_lut_builder_chk #(
  .MAX_PAIRS(MAX_PAIRS), .GRID_LOG2(GRID_LOG2), .ADDR_W(ADDR_W), .GK_W(GK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en), .rd_addr(rd_addr),
  .lut_we(lut_we), .lut_addr(lut_addr), .busy(busy), .done(done)
);

// File: tb/sim_cal_lut_builder.sv
module sim_cal_lut_builder;
  localparam int MAXP = 60;
  localparam int VW   = 12;
  localparam int GL   = 3;
  localparam int CW   = $clog2(MAXP + 1);
  localparam int AW   = $clog2(MAXP);
  localparam int NPTS = (1 << GL) + 1;
  localparam int VMAX = (1 << VW) - 1;

  logic clk, rst_n, start, mode;
  logic [CW-1:0]   pair_count;
  logic            rd_en;
  logic [AW-1:0]   rd_addr;
  logic [2*VW-1:0] rd_data;
  logic            lut_we;
  logic [GL:0]     lut_addr;
  logic [VW-1:0]   lut_data;
  logic            busy, done;

  cal_lut_builder #(.MAX_PAIRS(MAXP), .VAL_W(VW), .GRID_LOG2(GL)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pair_count(pair_count),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .lut_we(lut_we), .lut_addr(lut_addr), .lut_data(lut_data),
    .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  logic [2*VW-1:0] mem [64];
  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  int n_checks = 0;
  int n_err = 0;
  int exp_a[$];
  int exp_d[$];
  int n_exp;

  task automatic chk(bit ok, string tag, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic put(int i, int code, int phys);
    mem[i] = {code[VW-1:0], phys[VW-1:0]};
  endtask

  // behavioural reference: first-wins dedupe, ordered list, per-point line
  task automatic build_expect(int cnt, bit md);
    int k[$];
    int d[$];
    int n;
    n = (cnt > MAXP) ? MAXP : cnt;
    n_exp = n;
    exp_a.delete();
    exp_d.delete();
    for (int i = 0; i < n; i++) begin
      int code, phys, key, dep, p;
      bit seen;
      code = int'(mem[i][2*VW-1:VW]);
      phys = int'(mem[i][VW-1:0]);
      key = md ? code : phys;
      dep = md ? phys : code;
      seen = 0;
      p = 0;
      foreach (k[j]) begin
        if (k[j] == key) seen = 1;
        if (k[j] < key) p = j + 1;
      end
      if (!seen) begin
        k.insert(p, key);
        d.insert(p, dep);
      end
    end
    for (int g = 0; g < NPTS; g++) begin
      int x, y, c, lo;
      x = g * (1 << (VW - GL));
      if (x > VMAX) x = VMAX;
      if (k.size() == 0) y = 0;
      else if (k.size() == 1) y = d[0];
      else begin
        c = 0;
        foreach (k[j]) if (k[j] <= x) c++;
        lo = (c == 0) ? 0 : c - 1;
        if (lo > k.size() - 2) lo = k.size() - 2;
        y = d[lo] + ((d[lo+1] - d[lo]) * (x - k[lo])) / (k[lo+1] - k[lo]);
        if (y < 0) y = 0;
        if (y > VMAX) y = VMAX;
      end
      exp_a.push_back(g);
      exp_d.push_back(y);
    end
  endtask

  task automatic run_build(int cnt, bit md, string tag, int mid);
    int cyc, rd_exp, a, dv;
    bit fin;
    build_expect(cnt, md);
    @(negedge clk);
    mode = md;
    pair_count = CW'(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
    cyc = 0;
    rd_exp = 0;
    fin = 0;
    while (!fin) begin
      if (rd_en) begin
        chk(int'(rd_addr) == rd_exp, "R2 read address order", int'(rd_addr), rd_exp);
        rd_exp++;
      end
      if (lut_we) begin
        if (exp_a.size() == 0) chk(0, "R6 surplus write", int'(lut_addr), -1);
        else begin
          a = exp_a.pop_front();
          dv = exp_d.pop_front();
          chk(int'(lut_addr) == a, "R6 entry address", int'(lut_addr), a);
          chk(int'(lut_data) == dv, tag, int'(lut_data), dv);
        end
      end
      if (done) begin
        chk(busy == 1'b0, "R11 busy low with done", int'(busy), 0);
        chk(exp_a.size() == 0, "R6 every entry written", exp_a.size(), 0);
        chk(rd_exp == n_exp, "R2 read count", rd_exp, n_exp);
        fin = 1;
      end else if (!busy) begin
        chk(0, "R1 busy dropped without done", 0, 1);
        fin = 1;
      end
      start = (cyc == mid);
      if (!fin) begin
        @(negedge clk);
        cyc++;
      end
    end
    start = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R11 done lasts one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    mode = 1'b0;
    pair_count = '0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    chk(done == 1'b0, "R11 reset done", int'(done), 0);
    chk(lut_we == 1'b0, "R6 reset write strobe", int'(lut_we), 0);
    chk(rd_en == 1'b0, "R2 reset read strobe", int'(rd_en), 0);

    // R9: nothing stored
    put(0, 777, 333);
    run_build(0, 1'b0, "R9 empty table", -1);

    // R10: single pair
    put(0, 1234, 700);
    run_build(1, 1'b0, "R10 single pair", -1);

    // R4: repeated key, earliest wins (physical value is the key)
    put(0, 0, 100);
    put(1, 2100, 2000);
    put(2, 2047, 2000);
    put(3, 2047, 2100);
    put(4, 4095, 4000);
    put(5, 3000, 3500);
    run_build(6, 1'b0, "R4 first stored key wins", -1);

    // R3: same storage, code as the key
    run_build(6, 1'b1, "R3 code keyed mode", -1);

    // R4: identical repeats
    put(0, 300, 500);
    put(1, 300, 500);
    put(2, 3900, 3000);
    put(3, 300, 500);
    put(4, 3900, 3000);
    run_build(5, 1'b0, "R4 identical pairs", -1);

    // R8: steep segment forces both clamp limits
    put(0, 3000, 2500);
    put(1, 1000, 1500);
    run_build(2, 1'b0, "R8 extrapolate and clamp", -1);
    put(0, 100, 1500);
    put(1, 50, 2500);
    run_build(2, 1'b0, "R8 falling extrapolation", -1);

    // R5, R7: shuffled storage, truncating interpolation
    for (int i = 0; i < 20; i++) put(i, $urandom_range(VMAX), $urandom_range(VMAX));
    run_build(20, 1'b1, "R5 unordered storage", -1);
    run_build(20, 1'b0, "R7 interpolation", -1);

    // R2 count clamp, R1 start during build ignored
    for (int i = 0; i < 64; i++) put(i, $urandom_range(VMAX), $urandom_range(VMAX));
    put(60, 0, 0);
    put(61, VMAX, VMAX);
    run_build(63, 1'b0, "R2 count clamped", 30);

    // R12: fresh build from changed memory
    put(0, 10, 4000);
    put(1, 4000, 10);
    run_build(2, 1'b1, "R12 rebuild", -1);

    repeat (5) begin
      @(negedge clk);
      chk(!lut_we && !rd_en && !busy, "R1 idle after build", int'(lut_we), 0);
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule